// File: doc/BRIEF.md
# Serial-Loaded Parallel Output Port

This block is a serial slave that gives a chip an 8-bit parallel output port driven from a four-wire serial bus in clock mode 0. While the select line is low, each rising edge of the serial clock takes one data bit, most significant bit first, into a shift register. At the same time the bit that falls off the top of the register goes back to the master on the return line, so the master reads the previous shift contents while it writes the new byte. When the select line returns high and exactly eight clock pulses were counted, the assembled byte moves into the output holding register that drives the port.

All bus inputs are oversampled by the block's own clock through a synchroniser, so the logic lives in a single clock domain with a synchronous active-low reset. The port pins and the return line are not tristated here. The block provides a value and a drive enable for each, and the pad ring turns a low enable into high impedance. The port enable follows the active-low output enable input directly. The return-line enable is high only while the block is selected.

Top module: `spi_out_port`

## Requirements
- R1: A synchronous reset (rst_n low at a clk edge) clears both the output holding register and the shift register to zero. After reset, port_o reads 0x00 and the next transfer returns eight zero bits on miso_o.
- R2: While ss_n is low, mosi is sampled on each rising edge of sck, most significant bit first. After exactly 8 rising edges, port_o equals the byte sent. It takes that value no later than the 4th clk rising edge after ss_n goes high.
- R3: If a transfer ends with any count of sck rising edges other than 8 (0, 5, 7 or 9, for example), port_o keeps its previous value.
- R4: port_o changes only as a result of ss_n going high. It stays constant for the whole of a transfer.
- R5: While selected, miso_o presents the shift register contents as they stood when ss_n fell, most significant bit first. The first bit is valid before the first rising edge of sck. Each later bit appears after a falling edge of sck.
- R6: miso_oe is 1 while ss_n is low and 0 while ss_n is high. A change of ss_n shows on miso_oe within 3 clk edges.
- R7: While ss_n is high, activity on sck and mosi changes neither the shift register nor port_o.
- R8: port_oe equals the inverse of oe_n at all times. oe_n has no effect on the value of port_o or on the loading of the holding register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock used to oversample the serial bus |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the master; idles low |
| mosi | input | 1 | Serial data from the master, MSB first |
| ss_n | input | 1 | Active-low slave select |
| oe_n | input | 1 | Active-low output enable for the parallel port |
| port_o | output | 8 | Parallel port value from the holding register |
| port_oe | output | 1 | Drive enable for the port pads; 0 means high impedance |
| miso_o | output | 1 | Serial data returned to the master |
| miso_oe | output | 1 | Drive enable for the return-line pad |

## Verification
The assertions assume a well-formed mode-0 bus as seen from clk. sck is low whenever ss_n changes, each sck level lasts at least four clk cycles, mosi is steady around every rising sck edge, and reset is held for at least two edges. The bench meets these conditions by changing inputs only on falling clk edges and by holding every sck level for eight clk cycles. It changes mosi only together with a falling sck edge, and it opens and closes select with sck low and eight idle cycles on either side. With this spacing every synchroniser delay settles before the bench samples.

// File: rtl/spi_out_pkg.sv
// Shared definitions for the serial-loaded output port.
// Assumes: bus pins are grouped in one packed struct so that they
// pass through a single synchroniser and stay aligned with one another.
package spi_out_pkg;

    // Bus pins as sampled from the pads, in one bundle.
    typedef struct packed {
        logic sck;
        logic ss_n;
        logic mosi;
    } spi_pins_t;

    // Idle value of the bus: clock low, deselected, data low.
    localparam spi_pins_t PINS_IDLE = '{sck: 1'b0, ss_n: 1'b1, mosi: 1'b0};

endpackage

// File: rtl/spi_out_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes: each input holds its level for longer than STAGES clk cycles,
// so a bit is never lost. Reset loads RST_VAL into every stage.
module spi_out_sync #(
    parameter int unsigned W       = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [STAGES];

    // Shift the input bundle through the register chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < int'(STAGES); s++) stage_q[s] <= RST_VAL;
        end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/spi_out_shifter.sv
// Mode-0 serial shifter with bit counter and return-line register.
// Finds sck edges on the synchronised pins, shifts mosi in MSB first on
// rising edges while selected, and moves the top bit to the return line
// on falling edges. Signals a load when select rises after exactly
// W clock pulses.
// Assumes: sck is low when select changes; W >= 2.
module spi_out_shifter #(
    parameter int unsigned W     = 8,
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck_s,
    input  logic             ss_n_s,
    input  logic             mosi_s,
    output logic [W-1:0]     shift_q,
    output logic [CNT_W-1:0] bit_cnt,
    output logic             load_o,
    output logic             miso_o,
    output logic             miso_oe_o
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(W);
    localparam logic [CNT_W-1:0] SAT_CNT  = CNT_W'(W + 1);

    logic sck_d;
    logic ss_n_d;
    logic sel;
    logic sck_rise;
    logic sck_fall;
    logic miso_q;

    // Delayed copies of the synchronised pins for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d  <= 1'b0;
            ss_n_d <= 1'b1;
        end else begin
            sck_d  <= sck_s;
            ss_n_d <= ss_n_s;
        end
    end

    assign sel      = !ss_n_s;
    assign sck_rise = sel && sck_s && !sck_d;
    assign sck_fall = sel && !sck_s && sck_d;
    assign load_o   = ss_n_s && !ss_n_d && (bit_cnt == FULL_CNT);

    // Shift register: takes one mosi bit per rising sck edge while selected.
    always_ff @(posedge clk) begin
        if (!rst_n)        shift_q <= '0;
        else if (sck_rise) shift_q <= {shift_q[W-2:0], mosi_s};
    end

    // Pulse counter: cleared while deselected, saturates one above full.
    always_ff @(posedge clk) begin
        if (!rst_n)                              bit_cnt <= '0;
        else if (!sel)                           bit_cnt <= '0;
        else if (sck_rise && bit_cnt != SAT_CNT) bit_cnt <= bit_cnt + 1'b1;
    end

    // Return line: follows the top bit while idle, advances on falling sck.
    always_ff @(posedge clk) begin
        if (!rst_n)                miso_q <= 1'b0;
        else if (!sel || sck_fall) miso_q <= shift_q[W-1];
    end

    assign miso_o    = miso_q;
    assign miso_oe_o = sel;

endmodule

// File: rtl/spi_out_latch.sv
// Output holding register for the parallel port.
// Keeps its value except in a cycle where load_i is high.
// Assumes: load_i is a single-cycle pulse from the shifter.
module spi_out_latch #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    // Capture the shifter contents on a completed transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= '0;
        else if (load_i) q_o <= d_i;
    end

endmodule

// File: rtl/spi_out_port.sv
// Top of the serial-loaded parallel output port.
// Synchronises the bus pins, shifts data in and out, and updates the
// holding register when select is released after a full byte.
// Assumes: pads turn a low enable into high impedance.
module spi_out_port #(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sck,
    input  logic             mosi,
    input  logic             ss_n,
    input  logic             oe_n,
    output logic [WIDTH-1:0] port_o,
    output logic             port_oe,
    output logic             miso_o,
    output logic             miso_oe
);

    import spi_out_pkg::*;

    localparam int unsigned CNT_W = $clog2(WIDTH + 2);

    spi_pins_t        pins_raw;
    spi_pins_t        pins_s;
    logic             ss_n_s;
    logic [WIDTH-1:0] shift_q;
    logic [CNT_W-1:0] bit_cnt;
    logic             load_en;

    assign pins_raw = '{sck: sck, ss_n: ss_n, mosi: mosi};

    spi_out_sync #(
        .W       ($bits(spi_pins_t)),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PINS_IDLE)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pins_raw),
        .q_o   (pins_s)
    );

    assign ss_n_s = pins_s.ss_n;

    spi_out_shifter #(
        .W     (WIDTH),
        .CNT_W (CNT_W)
    ) shifter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_s     (pins_s.sck),
        .ss_n_s    (ss_n_s),
        .mosi_s    (pins_s.mosi),
        .shift_q   (shift_q),
        .bit_cnt   (bit_cnt),
        .load_o    (load_en),
        .miso_o    (miso_o),
        .miso_oe_o (miso_oe)
    );

    spi_out_latch #(
        .W (WIDTH)
    ) latch_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_en),
        .d_i    (shift_q),
        .q_o    (port_o)
    );

    // Port pad enable follows the active-low output enable directly.
    assign port_oe = !oe_n;

endmodule

// File: rtl/spi_out_port_chk.sv
// Checker for spi_out_port, attached through bind.
// Assumes: a well-formed mode-0 bus, with reset held for two or more edges.
module spi_out_port_chk #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ss_n,
    input logic [WIDTH-1:0] port_o,
    input logic             miso_oe,
    input logic             ss_n_s,
    input logic [WIDTH-1:0] shift_q,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             load_en
);

    // R1: reset clears holding register and shifter.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (port_o == '0 && shift_q == '0));

    // R2: a load places the shifter contents on the port.
    a_r2_load_captures: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> port_o == $past(shift_q));

    // R4: the port changes only after a load request.
    a_r4_port_only_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        (port_o != $past(port_o)) |-> $past(load_en));

    // R6: the return line is not driven once a high select has propagated.
    a_r6_miso_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ss_n, 2) |-> !miso_oe);

    // R7: the shifter holds while deselected.
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n_s |=> $stable(shift_q));

    // R3: the counter never runs past its saturation value.
    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(bit_cnt) <= int'(WIDTH) + 1);

endmodule

bind spi_out_port spi_out_port_chk #(
    .WIDTH (WIDTH),
    .CNT_W (CNT_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ss_n    (ss_n),
    .port_o  (port_o),
    .miso_oe (miso_oe),
    .ss_n_s  (ss_n_s),
    .shift_q (shift_q),
    .bit_cnt (bit_cnt),
    .load_en (load_en)
);

// File: tb/spi_out_port_tb.sv
// Self-checking bench for spi_out_port: sweeps every byte value and
// adds short, long, idle-noise, enable and mid-run reset cases.
module spi_out_port_tb_top;

    localparam int HALF = 8;

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck   = 1'b0;
    logic       mosi  = 1'b0;
    logic       ss_n  = 1'b1;
    logic       oe_n  = 1'b0;
    logic [7:0] port_o;
    logic       port_oe;
    logic       miso_o;
    logic       miso_oe;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] model_sh   = 8'h00;
    logic [7:0] model_port = 8'h00;

    always #2 clk = ~clk;

    spi_out_port dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck     (sck),
        .mosi    (mosi),
        .ss_n    (ss_n),
        .oe_n    (oe_n),
        .port_o  (port_o),
        .port_oe (port_oe),
        .miso_o  (miso_o),
        .miso_oe (miso_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        n_cmp++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One transfer of n bits taken from bits[n-1:0], MSB first.
    task automatic xfer(input logic [15:0] bits, input int n);
        ss_n = 1'b0;
        idle(HALF);
        chk("R6 miso_oe selected", miso_oe, 1'b1);
        for (int i = n - 1; i >= 0; i--) begin
            mosi = bits[i];
            idle(HALF);
            chk("R5 miso bit", miso_o, model_sh[7]);
            chk("R4 port steady", port_o, model_port);
            sck = 1'b1;
            model_sh = {model_sh[6:0], bits[i]};
            idle(HALF);
            sck = 1'b0;
        end
        idle(HALF);
        ss_n = 1'b1;
        if (n == 8) model_port = model_sh;
        @(posedge clk); @(posedge clk); @(posedge clk); @(posedge clk);
        @(negedge clk);
        if (n == 8) chk("R2 port after byte", port_o, model_port);
        else        chk("R3 port kept", port_o, model_port);
        idle(HALF);
        chk("R6 miso_oe released", miso_oe, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(2);
        chk("R1 port after reset", port_o, 8'h00);
        chk("R6 miso_oe idle", miso_oe, 1'b0);
        chk("R8 port_oe on", port_oe, 1'b1);

        // R2/R5/R1: all byte values; the first returns the zeroed shifter.
        for (int v = 0; v < 256; v++) xfer({8'h00, 8'(v)}, 8);

        // R3: wrong pulse counts keep the port.
        xfer(16'h0015, 5);
        xfer(16'h006A, 7);
        xfer(16'h01C3, 9);
        xfer(16'h0000, 0);
        xfer(16'h005A, 8);

        // R7: bus noise while deselected.
        for (int i = 0; i < 8; i++) begin
            mosi = i[0];
            sck = 1'b1;
            idle(HALF);
            chk("R7 miso_oe idle", miso_oe, 1'b0);
            sck = 1'b0;
            idle(HALF);
        end
        mosi = 1'b0;
        chk("R7 port untouched", port_o, model_port);
        xfer(16'h00E1, 8);

        // R8: enable gates only the pad enable.
        oe_n = 1'b1;
        idle(1);
        chk("R8 port_oe off", port_oe, 1'b0);
        chk("R8 value kept", port_o, model_port);
        xfer(16'h0037, 8);
        oe_n = 1'b0;
        idle(1);
        chk("R8 port_oe back", port_oe, 1'b1);
        chk("R8 value loaded", port_o, 8'h37);

        // R1: reset in mid-run.
        xfer(16'h00BD, 8);
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        model_sh = 8'h00;
        model_port = 8'h00;
        chk("R1 port after late reset", port_o, 8'h00);
        xfer(16'h0099, 8);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule